// File: doc/BRIEF.md
# Bit-Reversed Pulse Audio Modulator

This block turns offset-binary audio samples into a one-bit stream that can feed a simple analog low-pass stage. A free-running modulation counter advances every clock. The output is high whenever the active sample is greater than that counter with its bit order mirrored. Over one full counter span the number of high clocks equals the sample value, as with plain pulse-width modulation. The high clocks are scattered across the span instead of forming one block, which moves the modulation energy to higher frequencies.

The sample period comes from a separate count-down timer that is not tied to the counter wrap, so any period of `reload_val + 1` clocks can be used. The timer is a two-state machine. `TMR_EXPIRE` is the expiry cycle. It loads `reload_val` and follows one of two transitions: expire→count when the reload is nonzero, or expire→expire when the reload is zero. `TMR_COUNT` decrements the timer. It follows count→count while the timer is above one and count→expire when the timer reaches one. In every expiry cycle, a valid sample offered by the external one-entry buffer moves into the active sample register. The `sample_taken` strobe then tells the buffer to clear its valid flag.

Top module: `brpwm_audio`

## Requirements
- R1: Synchronous active-high reset clears the modulation counter and the timer to zero and puts the timer in `TMR_EXPIRE`. It drives `pwm_out` low and sets `active_sample` to mid-scale, 2^(SAMPLE_W-1), which is 0x8000 for 16 bits. The first cycle after reset is therefore an expiry cycle.
- R2: The modulation counter is SAMPLE_W bits wide, advances by one every clock and wraps from 2^SAMPLE_W-1 to 0.
- R3: `pwm_out` is registered. After each clock edge it equals (`active_sample` > reversed counter), using the values held before that edge. Bit i of the reversed counter is counter bit SAMPLE_W-1-i.
- R4: While `active_sample` holds a value s for 2^SAMPLE_W consecutive clocks, `pwm_out` is high for exactly s of the following 2^SAMPLE_W clocks.
- R5: Expiry cycles are spaced `reload_val`+1 clocks apart. `reload_val` is read only in an expiry cycle.
- R6: In an expiry cycle with `buf_valid` high, `sample_taken` is high during that cycle, and `active_sample` equals `buf_sample` after the edge that ends it.
- R7: In an expiry cycle with `buf_valid` low, `sample_taken` stays low and `active_sample` keeps its value.
- R8: Outside expiry cycles, `buf_valid` and `buf_sample` have no effect: `sample_taken` stays low and `active_sample` is unchanged.
- R9: With `reload_val` = 0, every cycle is an expiry cycle, so a valid sample is taken every clock.
- R10: The sample period needs no relation to 2^SAMPLE_W. A sample may be replaced before the counter has visited all its values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reload_val | input | TIMER_W | Timer reload; sample period minus one |
| buf_sample | input | SAMPLE_W | Offset-binary sample held in the external buffer |
| buf_valid | input | 1 | External buffer holds a sample |
| pwm_out | output | 1 | One-bit modulated output |
| sample_taken | output | 1 | Strobe: buffered sample consumed this cycle |
| active_sample | output | SAMPLE_W | Sample currently being modulated |

## Verification
Two events can fall in the same cycle: timer expiry can coincide with the modulation counter wrap, and expiry can coincide with a valid buffered sample. A period of 2^SAMPLE_W clocks forces every expiry onto the wrap cycle. Under that alignment, every sample value is swept and the high clocks are counted over one full span. The valid flag is then toggled against a period of five clocks and against a zero reload, so valid samples land on expiry cycles as well as between them. A per-cycle reference model judges `sample_taken`, `active_sample` and `pwm_out` in each of these cases.

// File: rtl/brpwm_pkg.sv
package brpwm_pkg;

    typedef enum logic [0:0] {
        TMR_EXPIRE = 1'b0,
        TMR_COUNT  = 1'b1
    } tmr_state_t;

endpackage

// File: rtl/brpwm_timer.sv
module brpwm_timer
    import brpwm_pkg::*;
#(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TIMER_W-1:0] reload_val,
    output logic               expire
);

    tmr_state_t         state_q, state_d;
    logic [TIMER_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TMR_EXPIRE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_EXPIRE: begin
                cnt_d   = reload_val;
                state_d = (reload_val == '0) ? TMR_EXPIRE : TMR_COUNT;
            end
            TMR_COUNT: begin
                cnt_d   = cnt_q - TIMER_W'(1);
                state_d = (cnt_q == TIMER_W'(1)) ? TMR_EXPIRE : TMR_COUNT;
            end
            default: begin
                state_d = TMR_EXPIRE;
            end
        endcase
    end

    always_comb begin
        expire = (state_q == TMR_EXPIRE);
    end

    // R9: zero reload keeps the timer in the expiry state
    a_r9_zero_reload_stays: assert property (@(posedge clk) disable iff (rst)
        (state_q == TMR_EXPIRE && reload_val == '0) |=> (state_q == TMR_EXPIRE));

    // R5: nonzero reload starts a countdown from the reload value
    a_r5_reload_starts_count: assert property (@(posedge clk) disable iff (rst)
        (state_q == TMR_EXPIRE && reload_val != '0) |=>
        (state_q == TMR_COUNT && cnt_q == $past(reload_val)));

    // R5: counting steps down by one each clock
    a_r5_count_steps_down: assert property (@(posedge clk) disable iff (rst)
        (state_q == TMR_COUNT) |=> (cnt_q == $past(cnt_q) - TIMER_W'(1)));

endmodule

// File: rtl/brpwm_mod.sv
module brpwm_mod #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                pwm_out
);

    logic [SAMPLE_W-1:0] cnt_q;
    logic [SAMPLE_W-1:0] cnt_rev;
    logic                pwm_q;

    for (genvar i = 0; i < SAMPLE_W; i++) begin : g_rev
        assign cnt_rev[i] = cnt_q[SAMPLE_W-1-i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            pwm_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + SAMPLE_W'(1);
            pwm_q <= (sample > cnt_rev);
        end
    end

    always_comb begin
        pwm_out = pwm_q;
    end

    // R2: free-running counter advances by one and wraps
    a_r2_counter_steps: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == $past(cnt_q) + SAMPLE_W'(1)));

    // R3: output follows the comparison against the mirrored counter
    a_r3_output_compare: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pwm_out == ($past(sample) > $past(cnt_rev))));

endmodule

// File: rtl/brpwm_audio.sv
module brpwm_audio #(
    parameter int SAMPLE_W = 16,
    parameter int TIMER_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TIMER_W-1:0]  reload_val,
    input  logic [SAMPLE_W-1:0] buf_sample,
    input  logic                buf_valid,
    output logic                pwm_out,
    output logic                sample_taken,
    output logic [SAMPLE_W-1:0] active_sample
);

    localparam logic [SAMPLE_W-1:0] MID_SCALE = SAMPLE_W'(1) << (SAMPLE_W - 1);

    logic                expire;
    logic                take;
    logic [SAMPLE_W-1:0] active_q;

    brpwm_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .reload_val (reload_val),
        .expire     (expire)
    );

    assign take = expire && buf_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= MID_SCALE;
        end else if (take) begin
            active_q <= buf_sample;
        end
    end

    brpwm_mod #(.SAMPLE_W(SAMPLE_W)) u_mod (
        .clk     (clk),
        .rst     (rst),
        .sample  (active_q),
        .pwm_out (pwm_out)
    );

    always_comb begin
        sample_taken  = take;
        active_sample = active_q;
    end

    // R6: a taken sample becomes the active sample
    a_r6_take_loads: assert property (@(posedge clk) disable iff (rst)
        sample_taken |=> (active_sample == $past(buf_sample)));

    // R7: without a take the active sample holds
    a_r7_hold_without_take: assert property (@(posedge clk) disable iff (rst)
        !sample_taken |=> $stable(active_sample));

    // R8: a valid buffer outside expiry is not consumed
    a_r8_no_take_between: assert property (@(posedge clk) disable iff (rst)
        (buf_valid && !u_timer.expire) |-> !sample_taken);

endmodule

// File: tb/tb_brpwm_audio.sv
`timescale 1ns/1ps
module tb_brpwm_audio;

    localparam int W  = 6;
    localparam int TW = 8;
    localparam int SPAN = 1 << W;
    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] reload_val = TW'(SPAN - 1);
    logic [W-1:0]  buf_sample = '0;
    logic          buf_valid = 1'b0;
    logic          pwm_out;
    logic          sample_taken;
    logic [W-1:0]  active_sample;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    brpwm_audio #(.SAMPLE_W(W), .TIMER_W(TW)) dut (
        .clk           (clk),
        .rst           (rst),
        .reload_val    (reload_val),
        .buf_sample    (buf_sample),
        .buf_valid     (buf_valid),
        .pwm_out       (pwm_out),
        .sample_taken  (sample_taken),
        .active_sample (active_sample)
    );

    // reference model built from the requirements
    logic [W-1:0]  m_cnt;
    logic [TW-1:0] m_t;
    logic [W-1:0]  m_act;
    logic          m_pwm;

    function automatic logic [W-1:0] mirror(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_t = '0; m_act = MID; m_pwm = 1'b0;
        end else begin
            m_pwm = (m_act > mirror(m_cnt));
            if (m_t == '0 && buf_valid) m_act = buf_sample;
            m_t = (m_t == '0) ? reload_val : m_t - TW'(1);
            m_cnt = m_cnt + W'(1);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    int ones;
    int takes;

    task automatic tick();
        @(negedge clk);
        check("R3 pwm_out", int'(pwm_out), int'(m_pwm));
        check("R6/R7/R8 active_sample", int'(active_sample), int'(m_act));
        check("R5/R8 sample_taken", int'(sample_taken), int'((m_t == '0) && buf_valid));
        ones += int'(pwm_out);
        takes += int'(sample_taken);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pwm_out low", int'(pwm_out), 0);
        check("R1 reset mid-scale", int'(active_sample), int'(MID));
        rst = 1'b0;
        buf_valid = 1'b1;
        buf_sample = '0;
        #1;
        check("R1 first cycle expires", int'(sample_taken), 1);

        // R4 / R2 sweep: period = span, every expiry lands on the counter wrap
        for (int s = 0; s < SPAN; s++) begin
            buf_sample = W'(s);
            ones = 0;
            for (int k = 1; k <= 2 * SPAN; k++) begin
                if (k == SPAN + 1) ones = 0;
                tick();
            end
            check("R4 ones per span", ones, s);
        end

        // R7: no valid sample, active holds the last swept value
        buf_valid = 1'b0;
        for (int k = 0; k < 200; k++) tick();
        check("R7 held sample", int'(active_sample), SPAN - 1);

        // R8 / R10: period of five clocks, valid toggling
        reload_val = TW'(4);
        for (int i = 0; i < 300; i++) begin
            buf_valid = (i % 3 == 0);
            buf_sample = W'((i * 7) % SPAN);
            tick();
        end
        buf_valid = 1'b1;
        takes = 0;
        for (int k = 0; k < 50; k++) tick();
        check("R5 R10 takes in 50 clocks at period 5", takes, 10);

        // R9: zero reload, take every clock
        reload_val = '0;
        for (int k = 0; k < 10; k++) tick();
        takes = 0;
        for (int i = 0; i < 20; i++) begin
            buf_sample = W'(i + 3);
            tick();
        end
        check("R9 take every clock", takes, 20);
        check("R9 last sample active", int'(active_sample), 22);

        // R1: reset in the middle of a run
        rst = 1'b1;
        tick();
        check("R1 mid-run reset mid-scale", int'(active_sample), int'(MID));
        check("R1 mid-run reset pwm low", int'(pwm_out), 0);
        rst = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule